// File: doc/BRIEF.md
# Interrupt Aggregator with Register Port

The block collects seven raw interrupt sources: four push buttons, a timer, a DMA-done flag and an FFT-done flag. It merges them into one interrupt request line toward the processor. Each source first passes through a two-flop synchronizer. Each source can be set up on its own: it can be masked, it can be treated as a live level or as a latched edge, and its polarity can be inverted. Software can also clear a latched source or force it pending.

Software reaches the block through a plain synchronous register port. Each clock cycle the port takes a byte address, a write enable and write data, and it returns registered read data one cycle later. The six registers sit on word offsets: enable 0x00, edge mode 0x04, polarity 0x08, clear command 0x0C, set command 0x10, and merged status 0x14. A typical setup puts the buttons in rising-edge mode, the timer in high-level mode and the completion flags in whichever mode the firmware prefers.

Top module: `irq_aggregator`

## Requirements
- R1: While rst_n is low at a clock edge, the enable, edge-mode and polarity registers and every pending latch return to 0, irq_o is 0 and reg_rdata is 0.
- R2: A write to enable (0x00), edge mode (0x04) or polarity (0x08) stores bits 6:0 of the data. Reading those offsets returns the stored bits with bits 31:7 as zero.
- R3: Reads of the clear (0x0C) and set (0x10) offsets and of any unmapped offset return zero. Bits 31:7 of the status word always read zero.
- R4: In level mode (edge-mode bit 0), status bit i equals the synchronized source when polarity bit i is 1. It equals the inverted source when polarity bit i is 0.
- R5: In edge mode with polarity 1, a 0-to-1 change of source i sets pending bit i. The bit then stays set after the source falls, and status shows it.
- R6: In edge mode with polarity 0, a 1-to-0 change of source i sets pending bit i. A 0-to-1 change does not.
- R7: Writing 1 to bit i of the clear offset removes pending bit i. Bits written 0 are unaffected.
- R8: Writing 1 to bit i of the set offset makes pending bit i set.
- R9: When a detected edge and a clear write hit the same bit in the same cycle, the bit stays pending.
- R10: irq_o is the OR over all bits of (status AND enable), registered once.
- R11: A source change shows on irq_o three clock edges after it is applied in level mode and four clock edges after it is applied in edge mode. Reads return the value from the clock edge at which the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| src_raw | input | 7 | Asynchronous interrupt sources (3:0 buttons, 4 timer, 5 DMA done, 6 FFT done) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets these corner cases:
- A clear write landing in the same cycle as a freshly detected edge. A design that lets the clear win would lose the interrupt.
- Falling-edge detection under polarity 0, alongside a check that the opposite edge is ignored. An inverted detector would latch on the wrong transition.
- Latency counted edge by edge in level and edge mode. An extra or missing register would move irq_o by one cycle.
- Readback of the write-only command offsets and the unused upper bits. A design that stores or echoes them would return nonzero data.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants for the interrupt aggregator.
// Assumes an 8-bit byte address and 32-bit data words.
package irq_agg_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    // Word offsets software relies on.
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_EDGE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_POL    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_SET    = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync - two-flop synchronizer, one lane per source.
// Assumes the inputs are asynchronous single-bit levels. Both stages reset to 0.
module irq_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Pass each lane through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/irq_src_cell.sv
// Module: irq_src_cell - per-source edge detector, pending latch and status select.
// Assumes sync_in is already synchronized. If an edge or a set meets a clear in
// the same cycle, the edge or set wins.
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol,
    input  logic edge_mode,
    input  logic clr,
    input  logic set,
    output logic evt,
    output logic pend,
    output logic status
);
    logic prev;
    logic act_now;
    logic act_prev;

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sync_in;
    end

    // Adjust for polarity, then detect the active-going transition.
    always_comb begin
        act_now  = pol ? sync_in : ~sync_in;
        act_prev = pol ? prev : ~prev;
        evt      = act_now & ~act_prev;
    end

    // Update the pending latch; clear loses to an edge or a set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend & ~clr) | evt | set;
    end

    // Show the latched bit in edge mode and the live level otherwise.
    always_comb status = edge_mode ? pend : act_now;
endmodule

// File: rtl/irq_regs.sv
// Module: irq_regs - register file for enable, edge mode and polarity, plus
// command decode and registered read mux.
// Assumes one access per cycle. Only the low NSRC bits are stored.
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   status,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   edge_q,
    output logic [NSRC-1:0]   pol_q,
    output logic [NSRC-1:0]   clr_p,
    output logic [NSRC-1:0]   set_p,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD = DATA_W - NSRC;

    logic [NSRC-1:0] wbits;
    logic [PAD-1:0]  unused_wdata_hi;
    logic [NSRC-1:0] rsel;

    assign wbits           = wdata[NSRC-1:0];
    assign unused_wdata_hi = wdata[DATA_W-1:NSRC];

    // Store configuration words on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            edge_q <= '0;
            pol_q  <= '0;
        end else if (we) begin
            if (addr == OFF_ENABLE) en_q   <= wbits;
            if (addr == OFF_EDGE)   edge_q <= wbits;
            if (addr == OFF_POL)    pol_q  <= wbits;
        end
    end

    // Turn a write to a command offset into a one-cycle pulse.
    always_comb begin
        clr_p = (we && addr == OFF_CLR) ? wbits : '0;
        set_p = (we && addr == OFF_SET) ? wbits : '0;
    end

    // Select the readable word; command and unmapped offsets read zero.
    always_comb begin
        unique case (addr)
            OFF_ENABLE: rsel = en_q;
            OFF_EDGE:   rsel = edge_q;
            OFF_POL:    rsel = pol_q;
            OFF_STATUS: rsel = status;
            default:    rsel = '0;
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= {{PAD{1'b0}}, rsel};
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: irq_aggregator - top of the interrupt aggregator.
// Assumes src_raw is asynchronous. irq_o is a registered OR of the enabled status.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   src_raw,
    output logic              irq_o
);
    logic [NSRC-1:0] src_s;
    logic [NSRC-1:0] en_q, edge_q, pol_q, clr_p, set_p;
    logic [NSRC-1:0] evt, pend, status;

    irq_sync #(.W(NSRC)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_async(src_raw), .q_sync(src_s)
    );

    irq_regs #(.NSRC(NSRC)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .status(status), .en_q(en_q), .edge_q(edge_q),
        .pol_q(pol_q), .clr_p(clr_p), .set_p(set_p), .rdata(reg_rdata)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        irq_src_cell i_cell (
            .clk(clk), .rst_n(rst_n), .sync_in(src_s[g]), .pol(pol_q[g]),
            .edge_mode(edge_q[g]), .clr(clr_p[g]), .set(set_p[g]),
            .evt(evt[g]), .pend(pend[g]), .status(status[g])
        );
    end

    // Register the merged request line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(status & en_q);
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: irq_aggregator_chk - assertion checker bound to irq_aggregator.
// Assumes it sees the internal pulses and latches through the bind below.
module irq_aggregator_chk #(
    parameter int NSRC = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_o,
    input logic [NSRC-1:0] status,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] evt,
    input logic [NSRC-1:0] clr_p,
    input logic [NSRC-1:0] set_p
);
    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & en_q)) |=> irq_o);
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & en_q)) |=> !irq_o);
    // R7
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_p & ~set_p & ~evt)) |=> ((pend & $past(clr_p & ~set_p & ~evt)) == '0));
    // R8
    set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_p) |=> ((pend & $past(set_p)) == $past(set_p)));
    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));
    // R5
    pend_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_p | set_p | evt) == '0) |=> $stable(pend));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NSRC(NSRC)) i_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .status(status), .en_q(en_q),
    .pend(pend), .evt(evt), .clr_p(clr_p), .set_p(set_p)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  src_raw = '0;
    logic        irq_o;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_raw(src_raw),
        .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        @(posedge clk);
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        rd(8'h00, v); chk("R1 enable reset", v, 32'h0);
        rd(8'h04, v); chk("R1 edge reset", v, 32'h0);
        rd(8'h08, v); chk("R1 polarity reset", v, 32'h0);
        // R4: all low sources with polarity 0 read active
        rd(8'h14, v); chk("R4 low level active", v, 32'h7F);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 enable readback", v, 32'h7F);
        wr(8'h08, 32'hFFFF_FFA5); rd(8'h08, v); chk("R2 polarity readback", v, 32'h25);
        wr(8'h04, 32'h0000_0153); rd(8'h04, v); chk("R2 edge readback", v, 32'h53);
        rd(8'h0C, v); chk("R3 clear reads zero", v, 32'h0);
        rd(8'h10, v); chk("R3 set reads zero", v, 32'h0);
        rd(8'h18, v); chk("R3 unmapped reads zero", v, 32'h0);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h08, 32'h0);
        idle(2);
        rd(8'h14, v); chk("R3 status upper zero", v & 32'hFFFF_FF80, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(8'h08, 32'h10); wr(8'h00, 32'h10); idle(3);
        chk("R4 timer low inactive", {31'b0, irq_o}, 32'h0);
        @(negedge clk); src_raw[4] = 1'b1;
        @(posedge clk); #1 chk("R11 level edge1", {31'b0, irq_o}, 32'h0);
        @(posedge clk); #1 chk("R11 level edge2", {31'b0, irq_o}, 32'h0);
        @(posedge clk); #1 chk("R11 R10 level edge3", {31'b0, irq_o}, 32'h1);
        rd(8'h14, v); chk("R4 timer high status", v & 32'h10, 32'h10);
        @(negedge clk); src_raw[4] = 1'b0;
        idle(4);
        chk("R4 level follows fall", {31'b0, irq_o}, 32'h0);
        wr(8'h00, 32'h0); wr(8'h08, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(8'h08, 32'h01); wr(8'h04, 32'h01); wr(8'h00, 32'h01); idle(3);
        @(negedge clk); src_raw[0] = 1'b1;
        idle(3); chk("R11 edge edge3", {31'b0, irq_o}, 32'h0);
        @(posedge clk); #1 chk("R11 R5 edge edge4", {31'b0, irq_o}, 32'h1);
        @(negedge clk); src_raw[0] = 1'b0;
        idle(5);
        rd(8'h14, v); chk("R5 pending held", v & 32'h1, 32'h1);
        wr(8'h0C, 32'h7E); idle(2);
        rd(8'h14, v); chk("R7 zero bits keep pending", v & 32'h1, 32'h1);
        wr(8'h0C, 32'h01); idle(2);
        rd(8'h14, v); chk("R7 clear removes pending", v & 32'h1, 32'h0);
        chk("R7 irq low after clear", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(8'h04, 32'h02); wr(8'h00, 32'h02); idle(3);
        @(negedge clk); src_raw[1] = 1'b1; idle(5);
        rd(8'h14, v); chk("R6 rising ignored", v & 32'h2, 32'h0);
        @(negedge clk); src_raw[1] = 1'b0; idle(5);
        rd(8'h14, v); chk("R6 falling latched", v & 32'h2, 32'h2);
        chk("R6 irq on falling", {31'b0, irq_o}, 32'h1);
        wr(8'h0C, 32'h02); idle(2);
    endtask

    task automatic t_set();
        logic [31:0] v;
        wr(8'h04, 32'h20); wr(8'h00, 32'h20); wr(8'h08, 32'h20); idle(3);
        rd(8'h14, v); chk("R8 idle before set", v & 32'h20, 32'h0);
        wr(8'h10, 32'h20); idle(1);
        rd(8'h14, v); chk("R8 set forces pending", v & 32'h20, 32'h20);
        chk("R8 irq after set", {31'b0, irq_o}, 32'h1);
        wr(8'h0C, 32'h20); idle(2);
    endtask

    task automatic t_conflict();
        logic [31:0] v;
        wr(8'h04, 32'h01); wr(8'h08, 32'h01); wr(8'h00, 32'h0); idle(3);
        @(negedge clk); src_raw[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        // clear is presented at the edge where the detected edge latches
        wr(8'h0C, 32'h01); idle(1);
        rd(8'h14, v); chk("R9 edge beats clear", v & 32'h1, 32'h1);
        src_raw[0] = 1'b0;
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        t_reset();
        t_readback();
        t_level();
        t_rise();
        t_fall();
        t_set();
        t_conflict();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule